// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter that serves eight multiplexed analog inputs. A one-cycle start request, together with a 3-bit channel number and two clock-rate settings, launches one conversion. The block steers the analog multiplexer and drives an 8-bit trial code into an external DAC. It reads a single comparator bit back, and after a fixed number of conversion-clock periods it latches the final code and raises a done flag.

The conversion clock is a tick derived from the system clock in two stages. The first stage is a coarse divide of 2, 4 or 16. The second stage either halves that rate or passes it through. Every conversion lasts 160 of these periods. The first 12 are a sampling window. The eight bit trials are laid out at an even pitch over the remaining periods, most significant bit first.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While reset is held and right after it: busy_o=0, done_o=0, sample_o=0, result_o=0, trial_o=0, mux_sel_o=0.
- R2: A start_i high at a clock edge while busy_o=0 begins a conversion. busy_o is 1 and done_o is 0 after that edge, and mux_sel_o shows the chan_i value sampled at that edge.
- R3: One conversion period spans B×M system clocks. B is 2 for clk_div_i=00, 4 for 01 and 16 for 11. M is 1 when full_rate_i=1 and 2 when it is 0. Both settings are captured at the accepted start, and later changes do not affect the running conversion.
- R4: done_o rises exactly 160 conversion periods after the accepting edge, and busy_o falls at the same edge.
- R5: sample_o is 1 for exactly the first 12 conversion periods of a conversion. During that window trial_o is 8'h80.
- R6: Bits are resolved MSB first. A bit is kept when cmp_i=1 (the input is at or above the DAC level) and cleared when cmp_i=0, and the next lower bit is then set for its trial. With an ideal comparator, result_o equals the input code.
- R7: clk_div_i=10 gives the same period as 11.
- R8: start_i during a conversion is ignored (the conversion length and result are unchanged), and mux_sel_o holds its captured channel for the whole conversion.
- R9: result_o changes only at the edge where done_o rises, and holds its value afterwards. done_o stays 1 until the next accepted start clears it.
- R10: Bit k (k=0 for the MSB) is decided at the end of conversion period 12+18(k+1)-1. With cmp_i=0, trial_o moves from 8'h80 to 8'h40 exactly 30 periods after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled on each edge |
| chan_i | input | 3 | Input channel to convert |
| clk_div_i | input | 2 | Coarse system-clock divide select |
| full_rate_i | input | 1 | 1: conversion clock equals divided clock, 0: half of it |
| cmp_i | input | 1 | Comparator: 1 when input is at or above trial code |
| mux_sel_o | output | 3 | Analog multiplexer select |
| trial_o | output | 8 | Trial code to the DAC |
| sample_o | output | 1 | High during the sampling window |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 8 | Last completed conversion code |
| done_o | output | 1 | Result valid, cleared by next start |

## Verification
The bench counts system clocks from the accepting edge to the rise of done for every divide setting. This includes the reserved code 10, which a design that decoded only three codes would turn into a short or a wrong period. Input codes at both rails (00, FF) and around mid-scale (7F, 80) exercise the keep and clear decisions. A comparator-sense or bit-order error would return a wrong code. The bench also checks the sampling-window edge and the first trial step edge to the cycle, so that an off-by-one step pitch is caught. A mid-conversion retrigger together with channel and divider changes must leave both the length and the result untouched. A design that restarted or re-sampled its settings would finish late or convert the wrong input.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // coarse divide values of the system clock
    localparam int unsigned SAR_DIV_A = 2;
    localparam int unsigned SAR_DIV_B = 4;
    localparam int unsigned SAR_DIV_C = 16;
    // largest total ratio (coarse divide times two)
    localparam int unsigned SAR_MAX_RATIO = 2 * SAR_DIV_C;
    localparam int unsigned SAR_PRE_W     = $clog2(SAR_MAX_RATIO);

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_TRIAL  = 2'd2,
        PH_SETTLE = 2'd3
    } sar_phase_e;

    // total system clocks per conversion period; code 10 behaves as 11
    function automatic int unsigned sar_ratio(input logic [1:0] div_sel,
                                              input logic       full_rate);
        int unsigned base;
        case (div_sel)
            2'b00:   base = SAR_DIV_A;
            2'b01:   base = SAR_DIV_B;
            default: base = SAR_DIV_C;
        endcase
        return full_rate ? base : 2 * base;
    endfunction

endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler
    import sar_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [1:0] div_sel_i,
    input  logic       full_rate_i,
    input  logic       run_i,
    output logic       tick_o
);

    typedef struct packed {
        logic [SAR_PRE_W-1:0] cnt;
        logic [SAR_PRE_W-1:0] limit;
    } pre_state_t;

    pre_state_t st_d, st_q;

    assign tick_o = run_i && (st_q.cnt == st_q.limit);

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt   = '0;
            st_d.limit = SAR_PRE_W'(sar_ratio(div_sel_i, full_rate_i) - 1);
        end else if (run_i) begin
            if (tick_o) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + SAR_PRE_W'(1);
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sar_phase_timer.sv
module sar_phase_timer
    import sar_seq_pkg::*;
#(
    parameter int unsigned RES_BITS   = 8,
    parameter int unsigned SAMPLE_PER = 12,
    parameter int unsigned TOTAL_PER  = 160,
    localparam int unsigned STEP_PER  = (TOTAL_PER - SAMPLE_PER) / RES_BITS,
    localparam int unsigned PER_W     = $clog2(TOTAL_PER),
    localparam int unsigned SUB_W     = $clog2(STEP_PER + 1),
    localparam int unsigned IDX_W     = $clog2(RES_BITS)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tick_i,
    output sar_phase_e       phase_o,
    output logic             decide_o,
    output logic [IDX_W-1:0] decide_pos_o,
    output logic             finish_o
);

    localparam logic [PER_W-1:0] LAST_PER   = PER_W'(TOTAL_PER - 1);
    localparam logic [PER_W-1:0] LAST_SAMP  = PER_W'(SAMPLE_PER - 1);
    localparam logic [SUB_W-1:0] LAST_SUB   = SUB_W'(STEP_PER - 1);
    localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(RES_BITS - 1);

    typedef struct packed {
        sar_phase_e       phase;
        logic [PER_W-1:0] per;
        logic [SUB_W-1:0] sub;
        logic [IDX_W-1:0] idx;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       active;

    assign active       = (st_q.phase != PH_IDLE);
    assign phase_o      = st_q.phase;
    assign finish_o     = tick_i && active && (st_q.per == LAST_PER);
    assign decide_o     = tick_i && (st_q.phase == PH_TRIAL) && (st_q.sub == LAST_SUB);
    assign decide_pos_o = LAST_IDX - st_q.idx;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.phase = PH_SAMPLE;
            st_d.per   = '0;
            st_d.sub   = '0;
            st_d.idx   = '0;
        end else if (tick_i && active) begin
            st_d.per = st_q.per + PER_W'(1);
            case (st_q.phase)
                PH_SAMPLE: begin
                    if (st_q.per == LAST_SAMP) begin
                        st_d.phase = PH_TRIAL;
                        st_d.sub   = '0;
                    end
                end
                PH_TRIAL: begin
                    if (st_q.sub == LAST_SUB) begin
                        st_d.sub = '0;
                        if (st_q.idx == LAST_IDX) begin
                            st_d.phase = PH_SETTLE;
                        end else begin
                            st_d.idx = st_q.idx + IDX_W'(1);
                        end
                    end else begin
                        st_d.sub = st_q.sub + SUB_W'(1);
                    end
                end
                default: ;
            endcase
            if (finish_o) begin
                st_d.phase = PH_IDLE;
                st_d.per   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, per: '0, sub: '0, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int unsigned RES_BITS = 8,
    localparam int unsigned IDX_W   = $clog2(RES_BITS)
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                decide_i,
    input  logic [IDX_W-1:0]    pos_i,
    input  logic                cmp_i,
    input  logic                finish_i,
    output logic [RES_BITS-1:0] trial_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                done_o
);

    typedef struct packed {
        logic [RES_BITS-1:0] trial;
        logic [RES_BITS-1:0] result;
        logic                done;
    } sar_reg_t;

    sar_reg_t st_d, st_q;

    assign trial_o  = st_q.trial;
    assign result_o = st_q.result;
    assign done_o   = st_q.done;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.trial              = '0;
            st_d.trial[RES_BITS-1]  = 1'b1;
            st_d.done               = 1'b0;
        end else begin
            if (decide_i) begin
                st_d.trial[pos_i] = cmp_i;
                if (pos_i != '0) begin
                    st_d.trial[pos_i - IDX_W'(1)] = 1'b1;
                end
            end
            if (finish_i) begin
                st_d.result = st_d.trial;
                st_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int unsigned RES_BITS   = 8,
    parameter int unsigned CHAN_W     = 3,
    parameter int unsigned SAMPLE_PER = 12,
    parameter int unsigned TOTAL_PER  = 160
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CHAN_W-1:0]   chan_i,
    input  logic [1:0]          clk_div_i,
    input  logic                full_rate_i,
    input  logic                cmp_i,
    output logic [CHAN_W-1:0]   mux_sel_o,
    output logic [RES_BITS-1:0] trial_o,
    output logic                sample_o,
    output logic                busy_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                done_o
);

    localparam int unsigned IDX_W = $clog2(RES_BITS);

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
    } top_state_t;

    top_state_t       st_d, st_q;
    sar_phase_e       phase;
    logic             accept;
    logic             tick;
    logic             decide;
    logic [IDX_W-1:0] decide_pos;
    logic             finish;

    assign busy_o    = (phase != PH_IDLE);
    assign sample_o  = (phase == PH_SAMPLE);
    assign accept    = start_i && !busy_o;
    assign mux_sel_o = st_q.chan;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.chan = chan_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sar_prescaler u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .div_sel_i   (clk_div_i),
        .full_rate_i (full_rate_i),
        .run_i       (busy_o),
        .tick_o      (tick)
    );

    sar_phase_timer #(
        .RES_BITS   (RES_BITS),
        .SAMPLE_PER (SAMPLE_PER),
        .TOTAL_PER  (TOTAL_PER)
    ) u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (accept),
        .tick_i       (tick),
        .phase_o      (phase),
        .decide_o     (decide),
        .decide_pos_o (decide_pos),
        .finish_o     (finish)
    );

    sar_trial_reg #(
        .RES_BITS (RES_BITS)
    ) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .decide_i (decide),
        .pos_i    (decide_pos),
        .cmp_i    (cmp_i),
        .finish_i (finish),
        .trial_o  (trial_o),
        .result_o (result_o),
        .done_o   (done_o)
    );

endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk #(
    parameter int unsigned RES_BITS = 8,
    parameter int unsigned CHAN_W   = 3
)(
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic [CHAN_W-1:0]   mux_sel_o,
    input logic [RES_BITS-1:0] trial_o,
    input logic                sample_o,
    input logic                busy_o,
    input logic [RES_BITS-1:0] result_o,
    input logic                done_o
);

    localparam logic [RES_BITS-1:0] MSB_CODE = {1'b1, {(RES_BITS-1){1'b0}}};

    assert_chan_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mux_sel_o));

    assert_done_busy_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done_o) |-> $stable(result_o));

    assert_sample_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> (busy_o && trial_o == MSB_CODE));

    assert_end_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    assert_start_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o));

endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(
    .RES_BITS (RES_BITS),
    .CHAN_W   (CHAN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mux_sel_o (mux_sel_o),
    .trial_o   (trial_o),
    .sample_o  (sample_o),
    .busy_o    (busy_o),
    .result_o  (result_o),
    .done_o    (done_o)
);

// File: tb/sim_sar_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sar_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] chan_i = '0;
    logic [1:0] clk_div_i = '0;
    logic       full_rate_i = 1'b1;
    logic       cmp_i;
    logic [2:0] mux_sel_o;
    logic [7:0] trial_o;
    logic       sample_o;
    logic       busy_o;
    logic [7:0] result_o;
    logic       done_o;

    logic [7:0] vin_mem [8];
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    // ideal comparator on the selected input
    assign cmp_i = (vin_mem[mux_sel_o] >= trial_o);

    sar_seq_ctrl u0 (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .chan_i (chan_i),
        .clk_div_i (clk_div_i), .full_rate_i (full_rate_i), .cmp_i (cmp_i),
        .mux_sel_o (mux_sel_o), .trial_o (trial_o), .sample_o (sample_o),
        .busy_o (busy_o), .result_o (result_o), .done_o (done_o)
    );

    // {code[7:0], chan[2:0], div[1:0], full}
    localparam logic [13:0] VEC [8] = '{
        {8'hA7, 3'd0, 2'b00, 1'b1},
        {8'h00, 3'd1, 2'b00, 1'b0},
        {8'hFF, 3'd7, 2'b01, 1'b1},
        {8'h80, 3'd4, 2'b01, 1'b0},
        {8'h7F, 3'd6, 2'b00, 1'b1},
        {8'h01, 3'd3, 2'b11, 1'b1},
        {8'h3C, 3'd5, 2'b10, 1'b1},
        {8'hD2, 3'd2, 2'b11, 1'b0}
    };

    function automatic int ratio(input logic [1:0] d, input logic f);
        int b;
        b = (d == 2'b00) ? 2 : (d == 2'b01) ? 4 : 16;
        return f ? b : 2 * b;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // start at a negedge, return clocks from accepting edge to done
    task automatic run_conv(input logic [2:0] ch, input logic [1:0] d, input logic f,
                            output int cycles);
        @(negedge clk);
        start_i = 1'b1; chan_i = ch; clk_div_i = d; full_rate_i = f;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        cycles = 0;
        while (!done_o && cycles < 20000) begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int cyc;
        for (int i = 0; i < 8; i++) vin_mem[i] = 8'h00;

        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "busy", int'(busy_o), 0);
        check("R1", "done", int'(done_o), 0);
        check("R1", "sample", int'(sample_o), 0);
        check("R1", "result", int'(result_o), 0);
        check("R1", "trial", int'(trial_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "mux", int'(mux_sel_o), 0);

        // vector table: R3 R4 R6 R7
        for (int i = 0; i < 8; i++) begin
            logic [13:0] v;
            v = VEC[i];
            vin_mem[v[5:3]] = v[13:6];
            run_conv(v[5:3], v[2:1], v[0], cyc);
            check("R4_R3_R7", "conversion clocks", cyc, 160 * ratio(v[2:1], v[0]));
            check("R6", "result", int'(result_o), int'(v[13:6]));
            check("R2", "mux select", int'(mux_sel_o), int'(v[5:3]));
            check("R4", "busy at done", int'(busy_o), 0);
        end

        // R9 result and done hold while idle
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R9", "done holds", int'(done_o), 1);
        check("R9", "result holds", int'(result_o), 8'hD2);

        // R2 R5 R10 cycle-exact window and first steps, period = 2 clocks
        vin_mem[3] = 8'h00;
        @(negedge clk);
        start_i = 1'b1; chan_i = 3'd3; clk_div_i = 2'b00; full_rate_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check("R2", "busy after start", int'(busy_o), 1);
        check("R9", "done cleared by start", int'(done_o), 0);
        check("R9", "result kept at start", int'(result_o), 8'hD2);
        check("R5", "sample at start", int'(sample_o), 1);
        check("R5", "trial in sampling", int'(trial_o), 8'h80);
        repeat (12 * 2 - 1) @(posedge clk);
        @(negedge clk);
        check("R5", "sample last clock", int'(sample_o), 1);
        @(posedge clk);
        @(negedge clk);
        check("R5", "sample ended", int'(sample_o), 0);
        repeat (18 * 2 - 1) @(posedge clk);
        @(negedge clk);
        check("R10", "trial before first decision", int'(trial_o), 8'h80);
        @(posedge clk);
        @(negedge clk);
        check("R10", "trial after first decision", int'(trial_o), 8'h40);
        repeat (18 * 2) @(posedge clk);
        @(negedge clk);
        check("R10", "trial after second decision", int'(trial_o), 8'h20);
        while (!done_o) @(negedge clk);
        check("R6", "zero input result", int'(result_o), 0);

        // R8 retrigger, channel and divider changes mid-conversion
        vin_mem[2] = 8'h5C;
        vin_mem[5] = 8'hC3;
        @(negedge clk);
        start_i = 1'b1; chan_i = 3'd2; clk_div_i = 2'b00; full_rate_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        repeat (50) begin @(posedge clk); cyc++; end
        @(negedge clk);
        start_i = 1'b1; chan_i = 3'd5; clk_div_i = 2'b11; full_rate_i = 1'b0;
        while (!done_o && cyc < 20000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (cyc == 100) check("R8", "mux held", int'(mux_sel_o), 2);
        end
        start_i = 1'b0;
        check("R8_R3", "length with retrigger", cyc, 320);
        check("R8", "result of captured channel", int'(result_o), 8'h5C);
        @(posedge clk);
        @(negedge clk);
        check("R8", "no restart", int'(busy_o), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule